// File: doc/BRIEF.md
# Keyed-Register Watchdog Timer

This block is a watchdog timer controlled through a small 16-bit register window. A slow tick strobe, nominally one pulse per 10 ms, drives a 15-bit down-counter. Every control action is guarded by an exact 16-bit key value. Software arms the timer with a restart key, loads the count from a programmable timeout with a feed key, and can stop the timer only by writing two different keys to two registers, in order. Register reads return coded words, not single flag bits.

One tick before the counter would run out, a pre-expiry event is latched. It is visible in an event register and, when unmasked, on an interrupt output. If software does not feed the timer in time, the block emits a one-cycle reset request, records a timed-out status, and reloads itself. A debug input pauses counting unless an override bit keeps the watchdog alive. Only the power-on reset clears the configuration. The block's own reset request leaves the configuration untouched.

Top module: `keyed_wdog`

## Requirements
- R1: After power-on reset the timer is disabled, so offset 0x0C reads 0xDABE. Offset 0x10 reads 0x0000, offset 0x04 reads 0x7FFF, offset 0x14 reads 0x7FFF, and irqOut and rstReq are low.
- R2: Writing 0xFEED to offset 0x00 loads the counter from the timeout register, whether or not the timer is enabled. Any other value written there leaves the counter unchanged.
- R3: Offset 0x04 stores bits 14:0 of the written word. Bit 15 is discarded and reads back as 0.
- R4: A write of 0xCAFE to offset 0x0C disables the timer only if the most recent write to offsets 0x08 or 0x0C was 0x2BAD to offset 0x08. A lone 0xCAFE has no effect. Offset 0x0C reads 0xDABE while disabled and 0x0000 while enabled. A disabled counter does not move on ticks.
- R5: Writing 0xACED to offset 0x1C enables a disabled timer. Other values are ignored.
- R6: Offset 0x14 returns the count in bits 14:0. Each tick while the timer is counting lowers the count by one. Bit 15 reads 1 during the cycle in which such a tick is being applied, and 0 otherwise.
- R7: A counting tick that finds the count at 1 or 0 makes rstReq high for exactly the next cycle and reloads the counter from the timeout register. The timeout register keeps its value.
- R8: After an expiry, offset 0x10 reads 0xCFE8 until 0xE8B4 is written to it. Other values written there are ignored.
- R9: A counting tick that takes the count from 2 to 1 sets the event flag, read at bit 0 of offset 0x20. Writing 1 to that bit clears the flag. irqOut is high when the flag is set and mask bit 0 at offset 0x24 is set.
- R10: While bit 0 of offset 0x28 is set, the event flag is set again every cycle, so an acknowledge does not clear it.
- R11: Bit 1 of offset 0x18 mirrors dbgMode, and bit 0 is a stored keep-alive bit. While dbgMode is high and keep-alive is clear, ticks do not count. With keep-alive set, ticks count normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| tick | input | 1 | One-cycle strobe per 10 ms time unit |
| dbgMode | input | 1 | High while a debugger holds the system |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; rdData is zero when low |
| addr | input | 6 | Byte offset of the register accessed |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational from addr |
| irqOut | output | 1 | Pre-expiry interrupt (event AND mask) |
| rstReq | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest situation to reach is the disable sequence with stale state. The bench first sends the second key with nothing armed and shows that the timer stays enabled. It then sends both keys in order and shows that the counter freezes on later ticks. The expiry path needs the count to sit at exactly 2 and then 1 while software keeps its hands off. The bench therefore programs a short timeout of 5, feeds, and steps the tick strobe one pulse at a time, reading the count and the event flag after each step. Finally, it reads the count register during a tick cycle, which is the only way to observe the not-stable bit.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 15;

  localparam logic [ADDR_W-1:0] OFS_FEED = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_TMO  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_DIS1 = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_DIS2 = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_DBG  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_RSTR = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_FRC  = 6'h28;

  localparam logic [DATA_W-1:0] KEY_FEED   = 16'hFEED;
  localparam logic [DATA_W-1:0] KEY_DIS1   = 16'h2BAD;
  localparam logic [DATA_W-1:0] KEY_DIS2   = 16'hCAFE;
  localparam logic [DATA_W-1:0] KEY_RESUME = 16'hACED;
  localparam logic [DATA_W-1:0] KEY_CLRST  = 16'hE8B4;
  localparam logic [DATA_W-1:0] CODE_OFF   = 16'hDABE;
  localparam logic [DATA_W-1:0] CODE_BARK  = 16'hCFE8;

  typedef struct packed {
    logic             feed;
    logic             loadTmo;
    logic [CNT_W-1:0] tmoVal;
    logic             run;
  } dpCmd_t;
endpackage

// File: rtl/keyed_wdog_dp.sv
module keyed_wdog_dp
  import keyed_wdog_pkg::*;
#(
  parameter logic [CNT_W-1:0] TMO_RESET = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] timeout,
  output logic             preBark,
  output logic             expire,
  output logic             rstReq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  assign expire  = cmd.run && (count <= ONE);
  assign preBark = cmd.run && (count == TWO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= TMO_RESET;
      timeout <= TMO_RESET;
      rstReq  <= 1'b0;
    end else begin
      rstReq <= expire;
      if (cmd.loadTmo) timeout <= cmd.tmoVal;
      if (cmd.feed || expire) count <= timeout;
      else if (cmd.run)       count <= count - ONE;
    end
  end
endmodule

// File: rtl/keyed_wdog_ctrl.sv
module keyed_wdog_ctrl
  import keyed_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              dbgMode,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  timeout,
  input  logic              preBark,
  input  logic              expire,
  output dpCmd_t            cmd,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              enabled,
  output logic              armed,
  output logic              timedOut,
  output logic              keepBit
);
  logic maskBit, forceBit, evtFlag;
  logic wFeed, wTmo, wDis1, wDis2, wStat, wDbg, wRstr, wEvt, wMsk, wFrc;

  always_comb begin
    wFeed = wrEn && (addr == OFS_FEED);
    wTmo  = wrEn && (addr == OFS_TMO);
    wDis1 = wrEn && (addr == OFS_DIS1);
    wDis2 = wrEn && (addr == OFS_DIS2);
    wStat = wrEn && (addr == OFS_STAT);
    wDbg  = wrEn && (addr == OFS_DBG);
    wRstr = wrEn && (addr == OFS_RSTR);
    wEvt  = wrEn && (addr == OFS_EVT);
    wMsk  = wrEn && (addr == OFS_MSK);
    wFrc  = wrEn && (addr == OFS_FRC);
  end

  always_comb begin
    cmd.feed    = wFeed && (wrData == KEY_FEED);
    cmd.loadTmo = wTmo;
    cmd.tmoVal  = wrData[CNT_W-1:0];
    cmd.run     = enabled && tick && (!dbgMode || keepBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled  <= 1'b0;
      armed    <= 1'b0;
      timedOut <= 1'b0;
      maskBit  <= 1'b0;
      forceBit <= 1'b0;
      keepBit  <= 1'b0;
      evtFlag  <= 1'b0;
    end else begin
      if (wDis2 && armed && (wrData == KEY_DIS2)) enabled <= 1'b0;
      else if (wRstr && (wrData == KEY_RESUME))   enabled <= 1'b1;

      if (wDis1)      armed <= (wrData == KEY_DIS1);
      else if (wDis2) armed <= 1'b0;

      if (expire)                                timedOut <= 1'b1;
      else if (wStat && (wrData == KEY_CLRST))   timedOut <= 1'b0;

      if (wMsk) maskBit  <= wrData[0];
      if (wFrc) forceBit <= wrData[0];
      if (wDbg) keepBit  <= wrData[0];

      evtFlag <= (evtFlag && !(wEvt && wrData[0])) || preBark || forceBit;
    end
  end

  assign irqOut = evtFlag && maskBit;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        OFS_TMO:  rdData = {1'b0, timeout};
        OFS_DIS2: rdData = enabled ? '0 : CODE_OFF;
        OFS_STAT: rdData = timedOut ? CODE_BARK : '0;
        OFS_CNT:  rdData = {cmd.run, count};
        OFS_DBG:  rdData = {14'b0, dbgMode, keepBit};
        OFS_EVT:  rdData = {15'b0, evtFlag};
        OFS_MSK:  rdData = {15'b0, maskBit};
        OFS_FRC:  rdData = {15'b0, forceBit};
        default:  rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter logic [CNT_W-1:0] TMO_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              dbgMode,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rstReq
);
  dpCmd_t           cmd;
  logic [CNT_W-1:0] count, timeout;
  logic             preBark, expire, enabled, armed, timedOut, keepBit;

  keyed_wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .dbgMode(dbgMode),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .count(count), .timeout(timeout), .preBark(preBark), .expire(expire),
    .cmd(cmd), .rdData(rdData), .irqOut(irqOut), .enabled(enabled),
    .armed(armed), .timedOut(timedOut), .keepBit(keepBit)
  );

  keyed_wdog_dp #(.TMO_RESET(TMO_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .count(count), .timeout(timeout),
    .preBark(preBark), .expire(expire), .rstReq(rstReq)
  );
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
  import keyed_wdog_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             rstReq,
  input logic             enabled,
  input logic             armed,
  input logic             timedOut,
  input logic             dbgMode,
  input logic             keepBit,
  input logic             feedStb,
  input logic [CNT_W-1:0] count
);
  p_bark_sets_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> timedOut);

  p_bark_only_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(enabled));

  p_disable_needs_key1_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enabled) |-> $past(armed));

  p_off_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !feedStb) |=> $stable(count));

  p_debug_pause_r11: assert property (@(posedge clk) disable iff (!rstN)
    (dbgMode && !keepBit && !feedStb) |=> $stable(count));
endmodule

bind keyed_wdog keyed_wdog_chk u_chk (
  .clk(clk), .rstN(rstN), .rstReq(rstReq), .enabled(enabled), .armed(armed),
  .timedOut(timedOut), .dbgMode(dbgMode), .keepBit(keepBit),
  .feedStb(cmd.feed), .count(count)
);

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        dbgMode = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqOut, rstReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  keyed_wdog u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .dbgMode(dbgMode), .wrEn(wrEn),
    .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .irqOut(irqOut), .rstReq(rstReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic testReset();
    logic [15:0] v;
    rd(6'h0C, v); check("R1 disabled code", v, 16'hDABE);
    rd(6'h10, v); check("R1 status", v, 16'h0000);
    rd(6'h04, v); check("R1 timeout", v, 16'h7FFF);
    rd(6'h14, v); check("R1 count", v, 16'h7FFF);
    check("R1 irqOut", {15'b0, irqOut}, 16'h0);
    check("R1 rstReq", {15'b0, rstReq}, 16'h0);
  endtask

  task automatic testTimeoutFeed();
    logic [15:0] v;
    wr(6'h04, 16'hFFFF); rd(6'h04, v); check("R3 mask bit15", v, 16'h7FFF);
    wr(6'h04, 16'h8005); rd(6'h04, v); check("R3 store", v, 16'h0005);
    wr(6'h00, 16'hFEEE); rd(6'h14, v); check("R2 wrong key", v, 16'h7FFF);
    wr(6'h00, 16'hFEED); rd(6'h14, v); check("R2 feed reload", v, 16'h0005);
  endtask

  task automatic testRestart();
    logic [15:0] v;
    pulseTick(); rd(6'h14, v); check("R4 disabled no count", v, 16'h0005);
    wr(6'h1C, 16'hACEE); rd(6'h0C, v); check("R5 wrong key", v, 16'hDABE);
    wr(6'h1C, 16'hACED); rd(6'h0C, v); check("R5 enabled", v, 16'h0000);
  endtask

  task automatic testCount();
    logic [15:0] v;
    @(negedge clk);
    tick = 1'b1; rdEn = 1'b1; addr = 6'h14;
    #1 v = rdData;
    rdEn = 1'b0;
    check("R6 unstable bit", v, 16'h8005);
    @(negedge clk);
    tick = 1'b0;
    rd(6'h14, v); check("R6 decrement", v, 16'h0004);
  endtask

  task automatic testDisable();
    logic [15:0] v;
    wr(6'h0C, 16'hCAFE); rd(6'h0C, v); check("R4 lone key2", v, 16'h0000);
    wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); check("R4 disabled", v, 16'hDABE);
    pulseTick(); rd(6'h14, v); check("R4 frozen", v, 16'h0004);
    wr(6'h1C, 16'hACED);
  endtask

  task automatic testPreBark();
    logic [15:0] v;
    pulseTick(); pulseTick();
    rd(6'h20, v); check("R9 no event yet", v, 16'h0000);
    pulseTick();
    rd(6'h20, v); check("R9 event set", v, 16'h0001);
    check("R9 masked irq", {15'b0, irqOut}, 16'h0);
    wr(6'h24, 16'h0001);
    check("R9 irq unmasked", {15'b0, irqOut}, 16'h1);
    wr(6'h20, 16'h0001);
    rd(6'h20, v); check("R9 ack", v, 16'h0000);
    check("R9 irq cleared", {15'b0, irqOut}, 16'h0);
  endtask

  task automatic testExpiry();
    logic [15:0] v;
    check("R7 no early req", {15'b0, rstReq}, 16'h0);
    pulseTick();
    check("R7 reset request", {15'b0, rstReq}, 16'h1);
    rd(6'h14, v); check("R7 reload", v, 16'h0005);
    check("R7 pulse one cycle", {15'b0, rstReq}, 16'h0);
    rd(6'h04, v); check("R7 timeout kept", v, 16'h0005);
    rd(6'h10, v); check("R8 timed out", v, 16'hCFE8);
    wr(6'h10, 16'h1234); rd(6'h10, v); check("R8 wrong clear", v, 16'hCFE8);
    wr(6'h10, 16'hE8B4); rd(6'h10, v); check("R8 cleared", v, 16'h0000);
  endtask

  task automatic testForce();
    logic [15:0] v;
    wr(6'h28, 16'h0001);
    @(negedge clk);
    rd(6'h20, v); check("R10 forced event", v, 16'h0001);
    check("R10 irq", {15'b0, irqOut}, 16'h1);
    wr(6'h20, 16'h0001); rd(6'h20, v); check("R10 ack held", v, 16'h0001);
    wr(6'h28, 16'h0000); wr(6'h20, 16'h0001);
    rd(6'h20, v); check("R10 released", v, 16'h0000);
  endtask

  task automatic testDebug();
    logic [15:0] v;
    @(negedge clk); dbgMode = 1'b1;
    rd(6'h18, v); check("R11 debug shown", v, 16'h0002);
    pulseTick(); rd(6'h14, v); check("R11 paused", v, 16'h0005);
    wr(6'h18, 16'h0001);
    rd(6'h18, v); check("R11 keep bit", v, 16'h0003);
    pulseTick(); rd(6'h14, v); check("R11 kept counting", v, 16'h0004);
    @(negedge clk); dbgMode = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTimeoutFeed();
    testRestart();
    testCount();
    testDisable();
    testPreBark();
    testExpiry();
    testForce();
    testDebug();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule